// File: doc/BRIEF.md
# Gray-Shade Column Driver Core

This block is the digital core of a cascadable column driver for a gray-shade display. Pixel codes are 7 bits wide and arrive on a parallel bus. A shift clock carries them, and both of its edges transfer a code. The block samples the shift clock with its own system clock and detects each edge. Rising edges feed an even-code register bank and falling edges feed an odd-code bank. Each bank has 16 stages. A chip-select token starts a row. Once the device has taken 32 codes, it passes the token on, so several devices can share one data bus in a chain.

A load strobe copies all 32 shifted codes into per-channel holding latches in a single clock. A ramp-start pulse begins a conversion cycle. A 7-bit level counter then climbs from 0 to 127 in step with an external analog ramp, one step every `STEP_DIV` clocks. Each channel compares the counter against its latched code and drives a track signal. The track signal drops once the counter reaches the code, which tells the analog output stage to hold its sample. A direction input reverses two things: the order in which codes fill the channels, and which token pin is the input and which is the output.

There is no back-pressure on the pixel bus. While a token-armed row is in progress, every detected shift-clock edge consumes the code present on `pix_i`. Data, token and shift clock must be stable for at least one system clock around each shift-clock transition. `dir_i` must not change while a row is being shifted or loaded.

Top module: `gs_column_core`

## Requirements
- R1: After reset, `level_o` is 0, every `track_o` bit is 0 and both token outputs are 0.
- R2: A row starts on a rising shift-clock edge that finds the active token input high. Code n of the row (n = 0..31) is taken on the rising edge for even n and on the falling edge for odd n, so 16 full shift-clock periods carry one row.
- R3: With `dir_i` = 1, code n goes to channel n. With `dir_i` = 0, code n goes to channel 31-n.
- R4: With `dir_i` = 1, the token is read from `tok_l_i` and driven on `tok_r_o`. With `dir_i` = 0, it is read from `tok_r_i` and driven on `tok_l_o`. The other output stays 0.
- R5: The token output rises after the falling edge that takes code 31. It falls after the next rising shift-clock edge, so it is high for exactly one edge period.
- R6: Once 32 codes are taken, further shift-clock edges are ignored until a new token arrives. A token seen in the middle of a row is ignored.
- R7: `load_i` copies all 32 shifted codes into the channel latches in one clock. The latches keep their values through later shifting until the next load.
- R8: `ramp_start_i` sets `level_o` to 0 on the next clock. After that, `level_o` rises by 1 every `STEP_DIV` clocks and stays at 127 once it gets there.
- R9: A channel with latched code c > 0 drives track high from the clock after `ramp_start_i`. Track falls one clock after `level_o` first equals c and then stays low until the next ramp start. It is therefore high for c*`STEP_DIV`+1 clocks.
- R10: A channel whose latched code is 0 never drives track high.
- R11: In a chain, the token output of one device feeds the token input of the next. The second device takes the 32 codes that directly follow the first device's row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk_i | input | 1 | Shift clock, sampled by `clk`; both edges are active |
| pix_i | input | W (7) | Pixel code bus |
| dir_i | input | 1 | Fill order and token direction select |
| tok_l_i | input | 1 | Token input when `dir_i` = 1 |
| tok_r_i | input | 1 | Token input when `dir_i` = 0 |
| tok_l_o | output | 1 | Token output when `dir_i` = 0 |
| tok_r_o | output | 1 | Token output when `dir_i` = 1 |
| load_i | input | 1 | Copy the shifted row into the channel latches |
| ramp_start_i | input | 1 | Start a conversion cycle |
| level_o | output | W (7) | Current gray level, for keeping the ramp in step |
| track_o | output | CH (32) | Per-channel track (1) / hold (0) |

## Verification
The assertions watch the parts of the behaviour that can be seen at the ports on every cycle. These are: the level counter resets, steps by at most one and saturates; the token output rises only after a shift-clock fall and clears after a rise; and a track bit that has dropped stays low until the next ramp start. Only the directed scenarios can show which code reached which channel, in both fill directions. The same holds for the data a chained second device picks up, for mid-row tokens and surplus edges being ignored, and for latches holding their row until a load. The bench does this by measuring each channel's track duration over a whole conversion cycle.

// File: rtl/gsc_pkg.sv
package gsc_pkg;

  // Edge events seen on the sampled shift clock.
  typedef struct packed {
    logic rise;
    logic fall;
  } sclk_edge_t;

  // Even-numbered codes live in bank 0, odd-numbered codes in bank 1.
  function automatic int bank_of(input int code_idx);
    return code_idx % 2;
  endfunction

  // The oldest code of a bank sits in its last stage.
  function automatic int stage_of(input int code_idx, input int stages);
    return stages - 1 - (code_idx / 2);
  endfunction

endpackage

// File: rtl/gsc_token_ctl.sv
module gsc_token_ctl #(
  parameter int CH = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk_i,
  input  logic tok_in_i,
  output logic take_even_o,
  output logic take_odd_o,
  output logic tok_pend_o
);
  import gsc_pkg::*;

  localparam int IDX_W = $clog2(CH);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(CH - 1);

  logic             sclk_q;
  logic             busy_q;
  logic [IDX_W-1:0] idx_q;
  sclk_edge_t       edge_s;

  assign edge_s.rise = sclk_i & ~sclk_q;
  assign edge_s.fall = ~sclk_i & sclk_q;

  // A rising edge takes a code when a row is running or a token opens one.
  assign take_even_o = edge_s.rise & (busy_q | tok_in_i);
  assign take_odd_o  = edge_s.fall & busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q     <= 1'b0;
      busy_q     <= 1'b0;
      idx_q      <= '0;
      tok_pend_o <= 1'b0;
    end else begin
      sclk_q <= sclk_i;
      if (edge_s.rise) begin
        tok_pend_o <= 1'b0;
      end
      if (take_even_o) begin
        busy_q <= 1'b1;
        idx_q  <= idx_q + 1'b1;
      end
      if (take_odd_o) begin
        if (idx_q == LAST_IDX) begin
          busy_q     <= 1'b0;
          idx_q      <= '0;
          tok_pend_o <= 1'b1;
        end else begin
          idx_q <= idx_q + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/gsc_shift_bank.sv
module gsc_shift_bank #(
  parameter int STAGES = 16,
  parameter int W      = 7
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       en_i,
  input  logic [W-1:0]               din_i,
  output logic [STAGES-1:0][W-1:0]   stage_o
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_o <= '0;
    end else if (en_i) begin
      stage_o[0] <= din_i;
      for (int s = 1; s < STAGES; s++) begin
        stage_o[s] <= stage_o[s-1];
      end
    end
  end

endmodule

// File: rtl/gsc_level_ctr.sv
module gsc_level_ctr #(
  parameter int W        = 7,
  parameter int STEP_DIV = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_i,
  output logic [W-1:0] level_o
);

  localparam int PW = (STEP_DIV > 1) ? $clog2(STEP_DIV) : 1;
  localparam logic [PW-1:0] PRE_LAST  = PW'(STEP_DIV - 1);
  localparam logic [W-1:0]  LEVEL_TOP = '1;

  logic [PW-1:0] pre_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q   <= '0;
      level_o <= '0;
    end else if (start_i) begin
      pre_q   <= '0;
      level_o <= '0;
    end else if (pre_q == PRE_LAST) begin
      pre_q <= '0;
      if (level_o != LEVEL_TOP) begin
        level_o <= level_o + 1'b1;
      end
    end else begin
      pre_q <= pre_q + 1'b1;
    end
  end

endmodule

// File: rtl/gsc_channel.sv
module gsc_channel #(
  parameter int W = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] code_i,
  input  logic         start_i,
  input  logic [W-1:0] level_i,
  output logic         track_o
);

  logic [W-1:0] code_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q  <= '0;
      track_o <= 1'b0;
    end else begin
      if (load_i) begin
        code_q <= code_i;
      end
      if (start_i) begin
        track_o <= (code_q != '0);
      end else if (level_i == code_q) begin
        track_o <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/gs_column_core.sv
module gs_column_core #(
  parameter int CH       = 32,
  parameter int W        = 7,
  parameter int STEP_DIV = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sclk_i,
  input  logic [W-1:0]  pix_i,
  input  logic          dir_i,
  input  logic          tok_l_i,
  input  logic          tok_r_i,
  output logic          tok_l_o,
  output logic          tok_r_o,
  input  logic          load_i,
  input  logic          ramp_start_i,
  output logic [W-1:0]  level_o,
  output logic [CH-1:0] track_o
);
  import gsc_pkg::*;

  localparam int NBANK  = 2;
  localparam int STAGES = CH / NBANK;

  logic tok_in;
  logic take_even;
  logic take_odd;
  logic tok_pend;

  // Direction picks which pin carries the incoming token.
  assign tok_in  = dir_i ? tok_l_i : tok_r_i;
  assign tok_r_o = dir_i & tok_pend;
  assign tok_l_o = ~dir_i & tok_pend;

  gsc_token_ctl #(.CH(CH)) u_tok (
    .clk         (clk),
    .rst_n       (rst_n),
    .sclk_i      (sclk_i),
    .tok_in_i    (tok_in),
    .take_even_o (take_even),
    .take_odd_o  (take_odd),
    .tok_pend_o  (tok_pend)
  );

  logic [STAGES-1:0][W-1:0] bank_q [NBANK];

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    gsc_shift_bank #(.STAGES(STAGES), .W(W)) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .en_i    ((b == 0) ? take_even : take_odd),
      .din_i   (pix_i),
      .stage_o (bank_q[b])
    );
  end

  gsc_level_ctr #(.W(W), .STEP_DIV(STEP_DIV)) u_lvl (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (ramp_start_i),
    .level_o (level_o)
  );

  for (genvar ch = 0; ch < CH; ch++) begin : g_chan
    localparam int N_UP = ch;
    localparam int N_DN = CH - 1 - ch;
    logic [W-1:0] code_sel;

    assign code_sel = dir_i ? bank_q[bank_of(N_UP)][stage_of(N_UP, STAGES)]
                            : bank_q[bank_of(N_DN)][stage_of(N_DN, STAGES)];

    gsc_channel #(.W(W)) u_ch (
      .clk     (clk),
      .rst_n   (rst_n),
      .load_i  (load_i),
      .code_i  (code_sel),
      .start_i (ramp_start_i),
      .level_i (level_o),
      .track_o (track_o[ch])
    );
  end

endmodule

// File: rtl/gs_column_core_chk.sv
module gs_column_core_chk #(
  parameter int CH = 32,
  parameter int W  = 7
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sclk_i,
  input logic          dir_i,
  input logic          ramp_start_i,
  input logic          tok_l_o,
  input logic          tok_r_o,
  input logic [W-1:0]  level_o,
  input logic [CH-1:0] track_o
);

  localparam logic [W-1:0] LEVEL_TOP = '1;

  // R8
  lvl_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ramp_start_i |=> (level_o == '0));

  // R8
  lvl_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ramp_start_i |=> (level_o == $past(level_o) || level_o == $past(level_o) + W'(1)));

  // R8
  lvl_saturate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (level_o == LEVEL_TOP && !ramp_start_i) |=> (level_o == LEVEL_TOP));

  // R5
  tok_rise_after_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(tok_l_o | tok_r_o) && $stable(dir_i)) |-> !$past(sclk_i));

  // R5
  tok_clear_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((tok_l_o | tok_r_o) && $rose(sclk_i) && $stable(dir_i)) |=> !(tok_l_o | tok_r_o));

  for (genvar i = 0; i < CH; i++) begin : g_trk
    // R9
    trk_stays_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!track_o[i] && !ramp_start_i) |=> !track_o[i]);
  end

endmodule

bind gs_column_core gs_column_core_chk #(.CH(CH), .W(W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .sclk_i       (sclk_i),
  .dir_i        (dir_i),
  .ramp_start_i (ramp_start_i),
  .tok_l_o      (tok_l_o),
  .tok_r_o      (tok_r_o),
  .level_o      (level_o),
  .track_o      (track_o)
);

// File: tb/gs_column_core_tb_top.sv
`timescale 1ns/1ps
module gs_column_core_tb_top;

  localparam int CH   = 32;
  localparam int W    = 7;
  localparam int SD   = 2;
  localparam int HALF = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic          sclk = 1'b0;
  logic          dir = 1'b1;
  logic          load = 1'b0;
  logic          ramp = 1'b0;
  logic [W-1:0]  pix = '0;
  logic          tb_tok_l = 1'b0;
  logic          tb_tok_r = 1'b0;
  logic          d1_l_o, d1_r_o, d2_l_o, d2_r_o;
  logic [W-1:0]  lvl1, lvl2;
  logic [CH-1:0] trk1, trk2;

  int total = 0;
  int bad   = 0;
  int cnt_l = 0;
  int cnt_r = 0;
  int stream [72];
  int exp1 [CH];
  int exp2 [CH];
  bit done = 1'b0;

  gs_column_core #(.CH(CH), .W(W), .STEP_DIV(SD)) dut_i (
    .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .pix_i(pix), .dir_i(dir),
    .tok_l_i(tb_tok_l), .tok_r_i(tb_tok_r), .tok_l_o(d1_l_o), .tok_r_o(d1_r_o),
    .load_i(load), .ramp_start_i(ramp), .level_o(lvl1), .track_o(trk1));

  gs_column_core #(.CH(CH), .W(W), .STEP_DIV(SD)) dut2_i (
    .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .pix_i(pix), .dir_i(dir),
    .tok_l_i(d1_r_o), .tok_r_i(d1_l_o), .tok_l_o(d2_l_o), .tok_r_o(d2_r_o),
    .load_i(load), .ramp_start_i(ramp), .level_o(lvl2), .track_o(trk2));

  task automatic chk(input string tag, input int act, input int expv);
    total++;
    if (act != expv) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic fill(input int base, input int cnt, input int seed);
    for (int n = 0; n < cnt; n++) stream[base + n] = (n * seed + 3 * seed + 1) % 128;
  endtask

  // Model of the channel mapping (R3): code n -> channel n or 31-n.
  task automatic set_exp(input bit second, input int base, input logic d);
    for (int ch = 0; ch < CH; ch++) begin
      if (second) exp2[ch] = stream[base + (d ? ch : CH - 1 - ch)];
      else        exp1[ch] = stream[base + (d ? ch : CH - 1 - ch)];
    end
  endtask

  task automatic drive_half(input logic lv, input int d, input logic tk);
    sclk = lv;
    pix  = W'(d);
    tb_tok_l = dir ? tk : 1'b0;
    tb_tok_r = dir ? 1'b0 : tk;
    for (int k = 0; k < HALF; k++) begin
      @(negedge clk);
      cnt_l += int'(d1_l_o);
      cnt_r += int'(d1_r_o);
    end
  endtask

  // R2: even codes on rising edges, odd codes on falling edges.
  task automatic drive_row(input int cnt, input int extra_tok);
    cnt_l = 0;
    cnt_r = 0;
    @(negedge clk);
    for (int n = 0; n < cnt; n++) begin
      drive_half((n % 2) == 0, stream[n], (n == 0) || (n == extra_tok));
    end
    tb_tok_l = 1'b0;
    tb_tok_r = 1'b0;
  endtask

  task automatic do_load();
    @(negedge clk); load = 1'b1;
    @(negedge clk); load = 1'b0;
  endtask

  // R8 R9 R10: run one conversion cycle and time each track bit.
  task automatic check_cycle(input string tag);
    int hi1 [CH];
    int hi2 [CH];
    int lvl_err = 0;
    for (int ch = 0; ch < CH; ch++) begin hi1[ch] = 0; hi2[ch] = 0; end
    @(negedge clk); ramp = 1'b1;
    @(negedge clk); ramp = 1'b0;
    for (int j = 1; j <= 128 * SD + 4; j++) begin
      int lv;
      if (j > 1) @(negedge clk);
      lv = (j - 1) / SD;
      if (lv > 127) lv = 127;
      if (int'(lvl1) != lv) lvl_err++;
      for (int ch = 0; ch < CH; ch++) begin
        hi1[ch] += int'(trk1[ch]);
        hi2[ch] += int'(trk2[ch]);
      end
    end
    chk({tag, " R8 level sequence errors"}, lvl_err, 0);
    for (int ch = 0; ch < CH; ch++) begin
      chk($sformatf("%s R9 R10 dev1 ch%0d track clocks", tag, ch), hi1[ch],
          (exp1[ch] == 0) ? 0 : exp1[ch] * SD + 1);
      chk($sformatf("%s R9 R10 dev2 ch%0d track clocks", tag, ch), hi2[ch],
          (exp2[ch] == 0) ? 0 : exp2[ch] * SD + 1);
    end
  endtask

  task automatic t_reset();
    chk("R1 level after reset", int'(lvl1), 0);
    chk("R1 track after reset", int'(trk1), 0);
    chk("R1 tok_l_o after reset", int'(d1_l_o), 0);
    chk("R1 tok_r_o after reset", int'(d1_r_o), 0);
  endtask

  task automatic t_forward_row();
    fill(0, 32, 41);
    stream[0]  = 0;
    stream[31] = 127;
    drive_row(32, -1);
    chk("R4 R5 dir1 tok_r_o high samples", cnt_r, HALF);
    chk("R4 dir1 tok_l_o high samples", cnt_l, 0);
    chk("R5 tok_r_o held until next edge", int'(d1_r_o), 1);
    do_load();
    set_exp(1'b0, 0, 1'b1);
    check_cycle("fwd R2 R3 R7");
  endtask

  task automatic t_hold_until_load();
    fill(0, 32, 23);
    stream[5] = 0;
    drive_row(32, -1);
    check_cycle("noload R7");
    do_load();
    set_exp(1'b0, 0, 1'b1);
    set_exp(1'b1, 0, 1'b1);
    check_cycle("reload R7 R11");
  endtask

  task automatic t_cascade();
    fill(0, 68, 19);
    stream[32] = 0;
    stream[63] = 127;
    drive_row(68, -1);
    chk("R5 R6 single token pulse in chain row", cnt_r, HALF);
    do_load();
    set_exp(1'b0, 0, 1'b1);
    set_exp(1'b1, 32, 1'b1);
    check_cycle("chain R11 R6");
  endtask

  task automatic t_mid_token();
    fill(0, 32, 57);
    drive_row(32, 16);
    do_load();
    set_exp(1'b0, 0, 1'b1);
    check_cycle("midtok R6");
  endtask

  task automatic t_reverse_row();
    @(negedge clk); dir = 1'b0;
    fill(0, 32, 13);
    stream[31] = 0;
    stream[0]  = 126;
    drive_row(32, -1);
    chk("R4 R5 dir0 tok_l_o high samples", cnt_l, HALF);
    chk("R4 dir0 tok_r_o high samples", cnt_r, 0);
    do_load();
    set_exp(1'b0, 0, 1'b0);
    set_exp(1'b1, 0, 1'b0);
    check_cycle("rev R3");
  endtask

  initial begin
    for (int ch = 0; ch < CH; ch++) begin exp1[ch] = 0; exp2[ch] = 0; end
    fork
      begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_forward_row();
        t_hold_until_load();
        t_cascade();
        t_mid_token();
        t_reverse_row();
        done = 1'b1;
      end
      begin
        repeat (150000) @(negedge clk);
      end
    join_any
    disable fork;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule